// File: doc/BRIEF.md
# Stochastic Feedback Divider

This block divides one unipolar stochastic value by another. Two 8-bit binary operands, a dividend x and a divisor k, are turned into bit streams by two independent pseudo-random generators. The quotient stream is built by starting from the dividend stream and inserting extra ones into it. The insertion source is a feedback stream: the previous quotient bit ANDed with the inverted divisor bit, so it carries the value (x/k)(1 − k). A non-scaled adder merges the feedback into the dividend stream. It can only place a one where the dividend bit is 0. When a feedback one arrives on a cycle where the dividend bit is already 1, the adder keeps it in a small saturating backlog and places it on a later free cycle.

One operation takes a frame of 256 stream cycles. The ones in the quotient stream are counted, and the count is reported as an 8-bit quotient with a single-cycle `done` pulse. The two operand streams need no correlation with each other. An operand pair that would give a quotient above 1, or a zero divisor, is rejected at once: the error flag is raised and the quotient is set to 255.

Top module: `sc_feedback_divider`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and `quotient` is 0.
- R2: The dividend generator is an 8-bit register. It is loaded with 0x01 when an operation is accepted. In each frame cycle it yields the bit (state < dividend) and then moves to {state[6:0], state[7]^state[5]^state[4]^state[3]}.
- R3: The divisor generator is an 8-bit register. It is loaded with 0xA5 when an operation is accepted. In each frame cycle it yields the bit (state < divisor) and then moves to {state[6:0], state[7]^state[3]^state[2]^state[1]}.
- R4: The feedback bit in a frame cycle is the quotient bit of the previous frame cycle ANDed with the inverted divisor bit. In the first cycle of a frame the previous quotient bit counts as 0.
- R5: The quotient bit is 1 when the dividend bit is 1. Otherwise it is 1 when the feedback bit is 1 or the backlog is nonzero. When the dividend bit and the feedback bit are both 0 and the backlog is nonzero, the backlog decreases by one.
- R6: When the dividend bit and the feedback bit are both 1, the backlog increases by one, saturating at 7. The backlog is cleared when an operation is accepted.
- R7: A `start` seen while idle with a valid operand pair sets `busy` for exactly 256 cycles, starting on the next cycle. In the cycle after the last busy cycle, `done` is high for one cycle and `quotient` equals the number of ones in the quotient stream, saturated to 255. The quotient is held until the next `done`.
- R8: A `start` seen while idle with divisor < dividend, or with divisor = 0, runs no frame. Instead `done` pulses on the next cycle with `err` = 1 and `quotient` = 255. `err` stays set until the next accepted `start`, which clears it if the pair is valid.
- R9: A `start` seen while `busy` is high is ignored. It does not change the operands or the result of the running frame.
- R10: A valid pair with dividend 0 produces quotient 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request an operation (taken only while idle) |
| dividend | input | 8 | Binary dividend x, value x/256 |
| divisor | input | 8 | Binary divisor k, value k/256 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Last operand pair was invalid |
| quotient | output | 8 | Ones count of the quotient stream, saturated |

## Verification
The bench aims at the places where the feedback loop is easy to get wrong:

- **Dividend close to the divisor.** This drives the count to 256, so a missing saturation would wrap the quotient to 0. It also keeps the backlog under pressure, so a backlog that drops coincident insertions, or that never saturates, yields a count that differs from the model.
- **Zero dividend.** A loop seeded with a stale output bit would make ones appear out of nothing.
- **Start pulses during a frame.** A design that re-latches operands here would change the result.
- **Invalid pairs, including a zero divisor.** These must give the forced 255 and the error flag without a frame, and a following valid pair must clear the flag.

// File: rtl/sc_div_pkg.sv
package sc_div_pkg;
    localparam int SC_W      = 8;
    localparam int FRAME_LEN = 2 ** SC_W;
    typedef logic [SC_W-1:0] sc_word_t;
endpackage

// File: rtl/sc_lfsr_sng.sv
module sc_lfsr_sng
    import sc_div_pkg::*;
#(
    parameter sc_word_t SEED = 8'h01,
    parameter sc_word_t MASK = 8'hB8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  logic     step,
    input  sc_word_t level,
    output logic     bit_o
);
    sc_word_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d = SEED;
        end else if (step) begin
            st_d = {st_q[SC_W-2:0], ^(st_q & MASK)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEED;
        else        st_q <= st_d;
    end

    assign bit_o = (st_q < level);
endmodule

// File: rtl/sc_nsadd_pend.sv
module sc_nsadd_pend #(
    parameter int PEND_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    input  logic a_i,
    input  logic b_i,
    output logic sum_o
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;
    localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

    logic [PEND_W-1:0] pend_d, pend_q;
    logic              has_pend;

    assign has_pend = (pend_q != '0);
    assign sum_o    = a_i | b_i | has_pend;

    always_comb begin
        pend_d = pend_q;
        if (clear) begin
            pend_d = '0;
        end else if (en) begin
            if (a_i && b_i && (pend_q != PEND_MAX)) begin
                pend_d = pend_q + PEND_ONE;
            end else if (!a_i && !b_i && has_pend) begin
                pend_d = pend_q - PEND_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/sc_feedback_divider.sv
module sc_feedback_divider
    import sc_div_pkg::*;
#(
    parameter int       PEND_W = 3,
    parameter sc_word_t SEED_X = 8'h01,
    parameter sc_word_t SEED_K = 8'hA5,
    parameter sc_word_t MASK_X = 8'hB8,
    parameter sc_word_t MASK_K = 8'h8E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] dividend,
    input  logic [7:0] divisor,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic [7:0] quotient
);
    localparam sc_word_t IDX_LAST = sc_word_t'(FRAME_LEN - 1);

    typedef struct packed {
        logic            busy;
        logic            done;
        logic            err;
        sc_word_t        quot;
        sc_word_t        x_lvl;
        sc_word_t        k_lvl;
        sc_word_t        idx;
        logic [SC_W:0]   ones;
        logic            out_prev;
    } div_state_t;

    div_state_t st_d, st_q;

    logic          x_bit, k_bit, fb_bit, out_bit;
    logic          accept, bad_pair;
    logic [SC_W:0] ones_next;

    assign accept   = start && !st_q.busy;
    assign bad_pair = (divisor < dividend) || (divisor == '0);

    sc_lfsr_sng #(.SEED(SEED_X), .MASK(MASK_X)) u_sng_x (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (st_q.busy),
        .level (st_q.x_lvl),
        .bit_o (x_bit)
    );

    sc_lfsr_sng #(.SEED(SEED_K), .MASK(MASK_K)) u_sng_k (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (st_q.busy),
        .level (st_q.k_lvl),
        .bit_o (k_bit)
    );

    assign fb_bit = st_q.out_prev & ~k_bit;

    sc_nsadd_pend #(.PEND_W(PEND_W)) u_nsadd (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .en    (st_q.busy),
        .a_i   (x_bit),
        .b_i   (fb_bit),
        .sum_o (out_bit)
    );

    assign ones_next = st_q.ones + {{SC_W{1'b0}}, out_bit};

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.ones     = ones_next;
            st_d.out_prev = out_bit;
            st_d.idx      = st_q.idx + sc_word_t'(1);
            if (st_q.idx == IDX_LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.quot = ones_next[SC_W] ? '1 : ones_next[SC_W-1:0];
            end
        end else if (start) begin
            st_d.x_lvl = dividend;
            st_d.k_lvl = divisor;
            if (bad_pair) begin
                st_d.err  = 1'b1;
                st_d.done = 1'b1;
                st_d.quot = '1;
            end else begin
                st_d.err      = 1'b0;
                st_d.busy     = 1'b1;
                st_d.idx      = '0;
                st_d.ones     = '0;
                st_d.out_prev = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign err      = st_q.err;
    assign quotient = st_q.quot;
endmodule

// File: rtl/sc_feedback_divider_chk.sv
module sc_feedback_divider_chk #(
    parameter int FRAME = 256
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [7:0] quotient
);
    logic [$clog2(FRAME+1)-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                   // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                   // R7
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == FRAME));                 // R7
    AST_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                             // R7
    AST_ERR_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (quotient == 8'hFF));            // R8
    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !err);                                    // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && (run_q < FRAME - 1)) |=> busy);  // R9
endmodule

bind sc_feedback_divider sc_feedback_divider_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .quotient (quotient)
);

// File: tb/sc_feedback_divider_bench.sv
`timescale 1ns/1ps
module sc_feedback_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] dividend = '0;
    logic [7:0] divisor = '0;
    logic       busy, done, err;
    logic [7:0] quotient;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    sc_feedback_divider u_sc_feedback_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .err(err), .quotient(quotient)
    );

    // behavioural reference model
    int m_busy, m_done, m_err, m_q, m_xl, m_kl, m_a, m_b, m_idx, m_pend, m_prev, m_cnt;

    function automatic int step_a(int s);
        int nb;
        nb = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
        return ((s << 1) & 255) | nb;
    endfunction

    function automatic int step_b(int s);
        int nb;
        nb = ((s >> 7) ^ (s >> 3) ^ (s >> 2) ^ (s >> 1)) & 1;
        return ((s << 1) & 255) | nb;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_q = 0; m_xl = 0; m_kl = 0;
            m_a = 1; m_b = 165; m_idx = 0; m_pend = 0; m_prev = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (m_busy != 0) begin
                int xb, kb, fb, o;
                xb = (m_a < m_xl) ? 1 : 0;             // R2
                kb = (m_b < m_kl) ? 1 : 0;             // R3
                fb = (m_prev != 0 && kb == 0) ? 1 : 0; // R4
                if (xb != 0) begin
                    o = 1;
                    if (fb != 0 && m_pend < 7) m_pend++; // R6
                end else if (fb != 0) begin
                    o = 1;
                end else if (m_pend > 0) begin
                    o = 1; m_pend--;                   // R5
                end else begin
                    o = 0;
                end
                m_cnt += o; m_prev = o;
                m_a = step_a(m_a); m_b = step_b(m_b);
                if (m_idx == 255) begin
                    m_busy = 0; m_done = 1;
                    m_q = (m_cnt > 255) ? 255 : m_cnt; // R7
                end
                m_idx++;
            end else if (start) begin
                m_xl = dividend; m_kl = divisor;
                if (divisor < dividend || divisor == 0) begin
                    m_err = 1; m_done = 1; m_q = 255; // R8
                end else begin
                    m_err = 0; m_busy = 1; m_a = 1; m_b = 165;
                    m_idx = 0; m_pend = 0; m_prev = 0; m_cnt = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(busy == m_busy[0], "R7 busy", busy, m_busy);
            chk(done == m_done[0], "R7 done", done, m_done);
            chk(err == m_err[0], "R8 err", err, m_err);
            // quotient depends on R2 R3 R4 R5 R6 stream behaviour
            chk(quotient == m_q[7:0], "R2/R3/R4/R5/R6 quotient", quotient, m_q);
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
            $finish;
        end
    end

    task automatic run_op(input int x, input int k, input bit poke_mid);
        @(negedge clk);
        dividend = x[7:0]; divisor = k[7:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 400 && !done; i++) begin
            if (poke_mid && i == 100) begin
                dividend = 8'd3; divisor = 8'd250; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && err == 0 && quotient == 0, "R1 reset", quotient, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(64, 128, 0);
        chk(done == 1 && err == 0, "R7 done after frame", done, 1);
        chk(quotient == m_q[7:0], "R7 result", quotient, m_q);

        run_op(200, 255, 0);
        chk(quotient == m_q[7:0], "R5 result high ratio", quotient, m_q);

        run_op(250, 250, 0);
        chk(quotient == m_q[7:0], "R6 backlog pressure", quotient, m_q);

        run_op(0, 100, 0);
        chk(quotient == 0, "R10 zero dividend", quotient, 0);

        run_op(100, 50, 0);
        chk(err == 1 && quotient == 255, "R8 divisor below dividend", quotient, 255);

        run_op(0, 0, 0);
        chk(err == 1 && quotient == 255, "R8 zero divisor", quotient, 255);

        run_op(1, 1, 0);
        chk(err == 0, "R8 err cleared", err, 0);
        chk(quotient == m_q[7:0], "R4 minimum operands", quotient, m_q);

        run_op(90, 180, 1);
        chk(quotient == m_q[7:0] && m_xl == 90, "R9 start while busy", quotient, m_q);

        run_op(30, 240, 0);
        chk(quotient == m_q[7:0], "R2/R3 small ratio", quotient, m_q);

        repeat (3) @(negedge clk);
        chk(done == 0, "R7 done single pulse", done, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule